// File: doc/BRIEF.md
# Slot Buffer Control Unit

This block sits between the serial engine of a time-division-multiplexed converter port and the processor. It owns a small bank of receive shadow registers (filled word by word as slots arrive), transmit shadow registers (read word by word as slots leave), and the processor-facing receive and transmit buffer registers. One shared word pointer addresses both shadow banks and moves forward by one word for every slot that is enabled in either direction.

When an enabled slot arrives while the pointer's value equals the programmed 2-bit length code, the block performs a buffer swap. The pointer returns to zero, the receive shadows are copied into the receive buffers, the transmit buffers are copied into the transmit shadows, and an interrupt is raised. The length code therefore selects 1 to 4 words per swap. The block also counts slots from the frame start, so software can find its place again if the link between buffers and slots is lost.

Top module: `slot_buf_ctrl`

## Requirements
- R1: After reset, `buf_ptr`, `cur_slot`, `irq`, `irq_flag`, `tx_word` and every `cpu_rdata` location are zero.
- R2: On a `slot_end` strobe with `slot_tx_en` or `slot_rx_en` set, `buf_ptr` goes up by one unless a swap occurs. A strobe with both enables clear, or no strobe, leaves `buf_ptr` unchanged.
- R3: On a strobe with `slot_rx_en` set, `rx_word` is stored in the receive shadow at `buf_ptr`. A transmit-only slot writes no receive shadow, so that location keeps its previous word into the next swap.
- R4: A swap occurs on an enabled strobe when the value of `buf_ptr` before the increment equals `buf_len`. The pointer then becomes 0, which gives `buf_len`+1 words per swap. With code 0, every enabled slot swaps.
- R5: At a swap, all receive buffers take the receive shadow contents, including a word captured on that same strobe. Receive buffers change at no other time.
- R6: At a swap, all transmit shadows take the transmit buffer contents, including a processor write made in that same cycle. Transmit shadows change at no other time.
- R7: `tx_word` always shows the transmit shadow selected by the current `buf_ptr`. With code 3, buffer k is therefore sent in the k-th enabled slot after a swap.
- R8: `irq` is high for exactly the one cycle that follows a swap strobe.
- R9: `irq_flag` is set by a swap and cleared by `irq_clr`. When both occur in the same cycle, the set wins.
- R10: `cur_slot` becomes 0 in the cycle after `frame_start`. Otherwise it goes up by one (wrapping) on every `slot_end`, whatever the enables.
- R11: `cpu_we` writes `cpu_wdata` into transmit buffer `cpu_waddr`. `cpu_rdata` shows receive buffer `cpu_raddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame sync pulse, restarts slot numbering |
| slot_end | input | 1 | One-cycle strobe at the end of each slot |
| slot_tx_en | input | 1 | Current slot is enabled for transmit |
| slot_rx_en | input | 1 | Current slot is enabled for receive |
| rx_word | input | 16 | Left-justified word received in the current slot |
| tx_word | output | 16 | Transmit shadow word at the current pointer |
| buf_ptr | output | 2 | Shared shadow word pointer |
| cur_slot | output | 4 | Slot number within the frame |
| buf_len | input | 2 | Length code, words per swap minus one |
| cpu_we | input | 1 | Processor write strobe for transmit buffers |
| cpu_waddr | input | 2 | Transmit buffer index for write |
| cpu_wdata | input | 16 | Transmit buffer write data |
| cpu_raddr | input | 2 | Receive buffer index for read |
| cpu_rdata | output | 16 | Receive buffer read data |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| irq | output | 1 | One-cycle interrupt pulse after a swap |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Three events can coincide with a swap in the same clock: the capture of the last receive word, a processor write to a transmit buffer, and a software clear of the sticky flag. The bench drives each of these together with the final enabled strobe of a buffer. It then checks three results. The word received on that strobe must be readable from the receive buffers. The value written in that cycle must appear on `tx_word` when its slot comes round. The flag must read as set. Transmit-only and fully disabled slots inside a buffer show that the pointer and the capture path are separate.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    parameter int SBC_WORD_W = 16;
    parameter int SBC_PTR_W  = 2;
    parameter int SBC_SLOT_W = 4;
    localparam int SBC_NBUF  = 1 << SBC_PTR_W;

    typedef logic [SBC_WORD_W-1:0] word_t;
    typedef logic [SBC_PTR_W-1:0]  ptr_t;
    typedef logic [SBC_SLOT_W-1:0] slot_t;

    typedef struct packed {
        ptr_t  ptr;
        slot_t slot;
        logic  irq;
        logic  flag;
    } ctl_state_t;

    typedef struct packed {
        word_t [SBC_NBUF-1:0] rx_shd;
        word_t [SBC_NBUF-1:0] rx_buf;
        word_t [SBC_NBUF-1:0] tx_shd;
        word_t [SBC_NBUF-1:0] tx_buf;
    } reg_state_t;
endpackage

// File: rtl/sbc_addr_ctl.sv
module sbc_addr_ctl
    import sbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic slot_end,
    input  logic tx_en,
    input  logic rx_en,
    input  logic irq_clr,
    input  ptr_t buf_len,
    output ptr_t ptr_o,
    output logic swap_o,
    output slot_t slot_o,
    output logic irq_o,
    output logic flag_o
);
    ctl_state_t st_d, st_q;
    logic       active;

    always_comb begin
        st_d   = st_q;
        active = slot_end && (tx_en || rx_en);
        swap_o = active && (st_q.ptr == buf_len);
        if (swap_o) begin
            st_d.ptr = '0;
        end else if (active) begin
            st_d.ptr = st_q.ptr + ptr_t'(1);
        end
        if (frame_start) begin
            st_d.slot = '0;
        end else if (slot_end) begin
            st_d.slot = st_q.slot + slot_t'(1);
        end
        st_d.irq = swap_o;
        if (swap_o) begin
            st_d.flag = 1'b1;
        end else if (irq_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o  = st_q.ptr;
    assign slot_o = st_q.slot;
    assign irq_o  = st_q.irq;
    assign flag_o = st_q.flag;

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_end && (tx_en || rx_en)) |=> $stable(ptr_o));
    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && (tx_en || rx_en) && ptr_o == buf_len) |=> (ptr_o == '0));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |=> irq_o);
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |=> flag_o);
    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !swap_o) |=> !flag_o);
    // R10
    slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (slot_o == '0));
    // R10
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && !frame_start) |=> (slot_o == slot_t'($past(slot_o) + 1'b1)));
endmodule

// File: rtl/sbc_regs.sv
module sbc_regs
    import sbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ptr_t  ptr,
    input  logic  rx_wr,
    input  word_t rx_word,
    input  logic  swap,
    input  logic  cpu_we,
    input  ptr_t  cpu_waddr,
    input  word_t cpu_wdata,
    input  ptr_t  cpu_raddr,
    output word_t cpu_rdata,
    output word_t tx_word
);
    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_we) st_d.tx_buf[cpu_waddr] = cpu_wdata;
        if (rx_wr)  st_d.rx_shd[ptr]       = rx_word;
        if (swap) begin
            st_d.rx_buf = st_d.rx_shd;
            st_d.tx_shd = st_d.tx_buf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_rdata = st_q.rx_buf[cpu_raddr];
    assign tx_word   = st_q.tx_shd[ptr];

    // R5
    rx_buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(st_q.rx_buf));
    // R6
    tx_shd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(st_q.tx_shd));
    // R3
    rx_shd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_wr |=> $stable(st_q.rx_shd));
endmodule

// File: rtl/slot_buf_ctrl.sv
module slot_buf_ctrl
    import sbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        slot_end,
    input  logic        slot_tx_en,
    input  logic        slot_rx_en,
    input  logic [15:0] rx_word,
    output logic [15:0] tx_word,
    output logic [1:0]  buf_ptr,
    output logic [3:0]  cur_slot,
    input  logic [1:0]  buf_len,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_waddr,
    input  logic [15:0] cpu_wdata,
    input  logic [1:0]  cpu_raddr,
    output logic [15:0] cpu_rdata,
    input  logic        irq_clr,
    output logic        irq,
    output logic        irq_flag
);
    logic swap;

    sbc_addr_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .slot_end    (slot_end),
        .tx_en       (slot_tx_en),
        .rx_en       (slot_rx_en),
        .irq_clr     (irq_clr),
        .buf_len     (buf_len),
        .ptr_o       (buf_ptr),
        .swap_o      (swap),
        .slot_o      (cur_slot),
        .irq_o       (irq),
        .flag_o      (irq_flag)
    );

    sbc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr       (buf_ptr),
        .rx_wr     (slot_end && slot_rx_en),
        .rx_word   (rx_word),
        .swap      (swap),
        .cpu_we    (cpu_we),
        .cpu_waddr (cpu_waddr),
        .cpu_wdata (cpu_wdata),
        .cpu_raddr (cpu_raddr),
        .cpu_rdata (cpu_rdata),
        .tx_word   (tx_word)
    );
endmodule

// File: tb/slot_buf_ctrl_tb.sv
`timescale 1ns/1ps
module slot_buf_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 0, slot_end = 0, slot_tx_en = 0, slot_rx_en = 0;
    logic [15:0] rx_word = '0, cpu_wdata = '0;
    logic [1:0] buf_len = 2'd3, cpu_waddr = '0, cpu_raddr = '0;
    logic cpu_we = 0, irq_clr = 0;
    logic [15:0] tx_word, cpu_rdata;
    logic [1:0] buf_ptr;
    logic [3:0] cur_slot;
    logic irq, irq_flag;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    slot_buf_ctrl u_dut (.*);

    typedef struct packed {
        logic [1:0] len; logic tx; logic rx; logic [15:0] word;
        logic [1:0] ptr; logic irq;
    } vec_t;
    localparam vec_t VECS [8] = '{
        '{2'd3, 1'b1, 1'b1, 16'hA000, 2'd1, 1'b0},
        '{2'd3, 1'b0, 1'b0, 16'hDEAD, 2'd1, 1'b0},
        '{2'd3, 1'b1, 1'b0, 16'hBEEF, 2'd2, 1'b0},
        '{2'd3, 1'b0, 1'b1, 16'hB002, 2'd3, 1'b0},
        '{2'd3, 1'b1, 1'b1, 16'hC003, 2'd0, 1'b1},
        '{2'd0, 1'b1, 1'b1, 16'hD000, 2'd0, 1'b1},
        '{2'd1, 1'b1, 1'b1, 16'hE000, 2'd1, 1'b0},
        '{2'd1, 1'b1, 1'b1, 16'hF001, 2'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic tx, input logic rx, input logic [15:0] w,
                          input logic we, input logic [1:0] wa, input logic [15:0] wd,
                          input logic clr);
        @(negedge clk);
        slot_end = 1; slot_tx_en = tx; slot_rx_en = rx; rx_word = w;
        cpu_we = we; cpu_waddr = wa; cpu_wdata = wd; irq_clr = clr;
        @(negedge clk);
        slot_end = 0; slot_tx_en = 0; slot_rx_en = 0; cpu_we = 0; irq_clr = 0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [15:0] exp);
        cpu_raddr = a; #0.1;
        chk(req, {16'h0, cpu_rdata}, {16'h0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ptr", buf_ptr, 0); chk("R1 slot", cur_slot, 0);
        chk("R1 irq", irq, 0); chk("R1 flag", irq_flag, 0); chk("R1 tx", tx_word, 0);
        for (int i = 0; i < 4; i++) rd(2'(i), "R1 rdata", 16'h0);

        // R2 R3 R4 R8 table walk
        foreach (VECS[i]) begin
            buf_len = VECS[i].len;
            strobe(VECS[i].tx, VECS[i].rx, VECS[i].word, 0, 0, 0, 0);
            chk("R2/R4 ptr", buf_ptr, VECS[i].ptr);
            chk("R8 irq", irq, VECS[i].irq);
            if (i == 4) begin
                rd(2'd0, "R5 rx0", 16'hA000); rd(2'd1, "R3 rx1 untouched", 16'h0);
                rd(2'd2, "R3 rx2", 16'hB002); rd(2'd3, "R5 last word same cycle", 16'hC003);
            end
        end
        @(negedge clk);
        chk("R8 irq one cycle", irq, 0);
        rd(2'd0, "R5 rx0", 16'hE000); rd(2'd1, "R5 rx1", 16'hF001);

        // R3 transmit-only slot keeps old receive shadow word
        buf_len = 2'd3;
        strobe(1, 1, 16'h1110, 0, 0, 0, 0);
        strobe(1, 0, 16'h9999, 0, 0, 0, 0);
        strobe(1, 1, 16'h3330, 0, 0, 0, 0);
        strobe(1, 1, 16'h4440, 0, 0, 0, 0);
        rd(2'd0, "R3 rx0", 16'h1110); rd(2'd1, "R3 tx-only keeps", 16'hF001);
        rd(2'd2, "R3 rx2", 16'h3330); rd(2'd3, "R3 rx3", 16'h4440);

        // R11 R6 R7 processor writes and same-cycle write at swap
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cpu_we = 1; cpu_waddr = 2'(i); cpu_wdata = 16'h1111 * 16'(i + 1);
        end
        @(negedge clk); cpu_we = 0;
        chk("R6 shadow not loaded yet", tx_word, 0);
        strobe(1, 0, 0, 0, 0, 0, 0);
        strobe(1, 0, 0, 0, 0, 0, 0);
        strobe(1, 0, 0, 0, 0, 0, 0);
        chk("R6 no early load", tx_word, 0);
        strobe(1, 0, 0, 1, 2'd2, 16'h5555, 0);
        chk("R11/R7 tx slot0", tx_word, 16'h1111);
        strobe(1, 0, 0, 0, 0, 0, 0);
        chk("R7 tx slot1", tx_word, 16'h2222);
        strobe(1, 0, 0, 0, 0, 0, 0);
        chk("R6 same-cycle write", tx_word, 16'h5555);
        strobe(1, 0, 0, 0, 0, 0, 0);
        chk("R7 tx slot3", tx_word, 16'h4444);
        strobe(1, 0, 0, 0, 0, 0, 0);
        chk("R4 wrap", buf_ptr, 0);

        // R9 sticky flag
        chk("R9 flag set", irq_flag, 1);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        chk("R9 flag cleared", irq_flag, 0);
        strobe(1, 0, 0, 0, 0, 0, 0);
        strobe(1, 0, 0, 0, 0, 0, 0);
        strobe(1, 0, 0, 0, 0, 0, 0);
        chk("R9 flag stays clear", irq_flag, 0);
        strobe(1, 0, 0, 0, 0, 0, 1);
        chk("R9 set wins over clear", irq_flag, 1);

        // R10 slot numbering, R2 disabled slots
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        chk("R10 frame zero", cur_slot, 0);
        strobe(0, 0, 0, 0, 0, 0, 0);
        strobe(0, 0, 0, 0, 0, 0, 0);
        strobe(1, 1, 16'h7777, 0, 0, 0, 0);
        chk("R10 count", cur_slot, 3);
        chk("R2 disabled slots no step", buf_ptr, 1);
        for (int i = 0; i < 13; i++) strobe(0, 0, 0, 0, 0, 0, 0);
        chk("R10 wrap", cur_slot, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule